// File: doc/BRIEF.md
# Address-Folded Parity Cache Checker

This block guards the data array of a cache and the logic that steers accesses into it. It keeps one parity bit beside each stored word. That bit covers the data bits and also the word-address bits of the location. No address bits are written into the array. If corrupted data comes back on a read, the recomputed parity does not match. If the array returns the word held at another location, the parity also fails, because the address folded into the stored bit is not the address that was requested.

The block is purely a side path. Store and fill parity are produced combinationally in the same cycle as the write, and a partial store is merged into the old word here so that its parity covers the whole word. Loads are checked on every valid read response. A mismatch gives a registered one-cycle error pulse and sets a sticky flag, and neither holds up the pipeline. Checking address arithmetic or alignment belongs to other logic. A store that never reaches the array is a known blind spot and is not detected.

Top module: `addr_parity_checker`

## Requirements
- R1: For a fill, `fill_par_o` equals the XOR of all bits of `fill_data_i` and of the word-address bits `fill_addr_i[AW-1:2]`, in the same cycle and with no added latency.
- R2: For a store with all byte enables set, `st_data_o` equals `st_wdata_i` and `st_par_o` equals the XOR of `st_data_o` and `st_addr_i[AW-1:2]`.
- R3: For a partial store, byte lane k (bits 8k+7:8k) of `st_data_o` comes from `st_wdata_i` when `st_be_i[k]` is 1 and from `st_old_data_i` otherwise, and `st_par_o` is computed over the whole merged word.
- R4: A valid load whose data, address and stored parity are consistent under the rule of R1 produces no error.
- R5: A valid load with any single data bit flipped raises `err_o` on the cycle after the response.
- R6: A load that returns the word and parity stored at address B for a request to address A raises `err_o` when the word addresses of A and B differ in an odd number of bits. With an even number of differing bits the mismatch aliases and is not flagged.
- R7: `err_o` is high for exactly one cycle per failing response, and a mismatch presented while `ld_valid_i` is low does not raise it.
- R8: `err_sticky_o` sets with the first error and stays high until reset.
- R9: The byte-offset bits `addr[1:0]` do not affect any parity result.
- R10: During and after reset, `err_o` and `err_sticky_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| st_valid_i | input | 1 | Store write in this cycle |
| st_addr_i | input | AW | Store byte address |
| st_be_i | input | DW/8 | Store byte enables |
| st_wdata_i | input | DW | Store data, aligned to lanes |
| st_old_data_i | input | DW | Current array word at the store location |
| st_data_o | output | DW | Merged word to write |
| st_par_o | output | 1 | Parity bit to write with the merged word |
| fill_addr_i | input | AW | Fill byte address |
| fill_data_i | input | DW | Fill word from the next level |
| fill_par_o | output | 1 | Parity bit to write with the fill word |
| ld_valid_i | input | 1 | Valid read response |
| ld_addr_i | input | AW | Requested load address |
| ld_data_i | input | DW | Word returned by the array |
| ld_par_i | input | 1 | Parity bit returned by the array |
| err_o | output | 1 | One-cycle error pulse |
| err_sticky_o | output | 1 | Sticky error flag |

## Verification
The bench drives a load with the word and parity stored at a neighbouring address. A design that left the address out of the parity would pass that load silently. It also returns a word from an address at even Hamming distance, where no error is the correct result. A design that always flagged address differences would raise a false error there. Partial stores with mixed byte enables catch a merge that takes the wrong lane, or parity that covers only the new bytes, because the stored bit then disagrees on reload. Back-to-back failing and passing responses, and a mismatch held while the valid input is low, show whether the pulse stretches, fires on idle cycles, or lets the sticky flag drop.

// File: rtl/apc_pkg.sv
package apc_pkg;
  localparam int unsigned BYTE_W = 8;

  function automatic int unsigned ofs_bits(input int unsigned data_w);
    return $clog2(data_w / BYTE_W);
  endfunction
endpackage

// File: rtl/apc_par_gen.sv
module apc_par_gen #(
  parameter int unsigned DW  = 32,
  parameter int unsigned AW  = 16,
  parameter int unsigned OFS = 2
) (
  input  logic [DW-1:0] data_i,
  input  logic [AW-1:0] addr_i,
  output logic          par_o
);
  localparam int unsigned WAW = AW - OFS;

  logic [WAW-1:0] word_addr;
  assign word_addr = addr_i[AW-1:OFS];
  // byte offset excluded: one bit guards one word location
  assign par_o = (^data_i) ^ (^word_addr);
endmodule

// File: rtl/apc_byte_merge.sv
module apc_byte_merge #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0]                  old_i,
  input  logic [DW-1:0]                  new_i,
  input  logic [DW/apc_pkg::BYTE_W-1:0]  be_i,
  output logic [DW-1:0]                  merged_o
);
  localparam int unsigned BW = apc_pkg::BYTE_W;
  localparam int unsigned NB = DW / BW;

  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign merged_o[k*BW +: BW] = be_i[k] ? new_i[k*BW +: BW] : old_i[k*BW +: BW];
  end
endmodule

// File: rtl/apc_load_check.sv
module apc_load_check (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic par_calc_i,
  input  logic par_got_i,
  output logic err_o,
  output logic sticky_o
);
  logic hit_err;
  assign hit_err = valid_i && (par_calc_i != par_got_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o    <= 1'b0;
      sticky_o <= 1'b0;
    end else begin
      err_o <= hit_err;
      if (hit_err) sticky_o <= 1'b1;
    end
  end

  a_r7_pulse_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(valid_i));
  a_r8_sticky_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky_o |=> sticky_o);
  a_r8_sticky_covers_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> sticky_o);
endmodule

// File: rtl/addr_parity_checker.sv
module addr_parity_checker #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 16,
  localparam int unsigned NB = DW / apc_pkg::BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_valid_i,
  input  logic [AW-1:0] st_addr_i,
  input  logic [NB-1:0] st_be_i,
  input  logic [DW-1:0] st_wdata_i,
  input  logic [DW-1:0] st_old_data_i,
  output logic [DW-1:0] st_data_o,
  output logic          st_par_o,
  input  logic [AW-1:0] fill_addr_i,
  input  logic [DW-1:0] fill_data_i,
  output logic          fill_par_o,
  input  logic          ld_valid_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [DW-1:0] ld_data_i,
  input  logic          ld_par_i,
  output logic          err_o,
  output logic          err_sticky_o
);
  localparam int unsigned OFS = apc_pkg::ofs_bits(DW);

  logic ld_par_calc;

  apc_byte_merge #(.DW(DW)) u_merge (
    .old_i   (st_old_data_i),
    .new_i   (st_wdata_i),
    .be_i    (st_be_i),
    .merged_o(st_data_o)
  );

  apc_par_gen #(.DW(DW), .AW(AW), .OFS(OFS)) u_st_par (
    .data_i(st_data_o), .addr_i(st_addr_i), .par_o(st_par_o)
  );

  apc_par_gen #(.DW(DW), .AW(AW), .OFS(OFS)) u_fill_par (
    .data_i(fill_data_i), .addr_i(fill_addr_i), .par_o(fill_par_o)
  );

  apc_par_gen #(.DW(DW), .AW(AW), .OFS(OFS)) u_ld_par (
    .data_i(ld_data_i), .addr_i(ld_addr_i), .par_o(ld_par_calc)
  );

  apc_load_check u_check (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (ld_valid_i),
    .par_calc_i(ld_par_calc),
    .par_got_i (ld_par_i),
    .err_o     (err_o),
    .sticky_o  (err_sticky_o)
  );

  a_r2_full_store_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && (&st_be_i)) |-> (st_data_o == st_wdata_i));
  a_r3_no_enable_keeps_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && (st_be_i == '0)) |-> (st_data_o == st_old_data_i));
endmodule

// File: tb/addr_parity_checker_bench.sv
module addr_parity_checker_bench;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int NB = DW / 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          st_valid_i = 1'b0;
  logic [AW-1:0] st_addr_i = '0;
  logic [NB-1:0] st_be_i = '0;
  logic [DW-1:0] st_wdata_i = '0, st_old_data_i = '0;
  logic [DW-1:0] st_data_o;
  logic          st_par_o;
  logic [AW-1:0] fill_addr_i = '0;
  logic [DW-1:0] fill_data_i = '0;
  logic          fill_par_o;
  logic          ld_valid_i = 1'b0;
  logic [AW-1:0] ld_addr_i = '0;
  logic [DW-1:0] ld_data_i = '0;
  logic          ld_par_i = 1'b0;
  logic          err_o, err_sticky_o;

  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  addr_parity_checker #(.DW(DW), .AW(AW)) u_addr_parity_checker (
    .clk_i(clk), .rst_ni(rst_ni),
    .st_valid_i(st_valid_i), .st_addr_i(st_addr_i), .st_be_i(st_be_i),
    .st_wdata_i(st_wdata_i), .st_old_data_i(st_old_data_i),
    .st_data_o(st_data_o), .st_par_o(st_par_o),
    .fill_addr_i(fill_addr_i), .fill_data_i(fill_data_i), .fill_par_o(fill_par_o),
    .ld_valid_i(ld_valid_i), .ld_addr_i(ld_addr_i), .ld_data_i(ld_data_i),
    .ld_par_i(ld_par_i), .err_o(err_o), .err_sticky_o(err_sticky_o)
  );

  function automatic logic ref_par(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic p = 1'b0;
    for (int i = 0; i < DW; i++) p = p ^ d[i];
    for (int i = 2; i < AW; i++) p = p ^ a[i];
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive a load at negedge, return err_o one cycle later
  task automatic do_load(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic p,
                         input logic v, output logic e);
    @(negedge clk);
    ld_valid_i = v; ld_addr_i = a; ld_data_i = d; ld_par_i = p;
    @(negedge clk);
    ld_valid_i = 1'b0;
    #1 e = err_o;
  endtask

  task automatic t_reset;
    chk(err_o == 1'b0, "R10 err in reset", err_o, 0);
    chk(err_sticky_o == 1'b0, "R10 sticky in reset", err_sticky_o, 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk); #1;
    chk(err_o == 1'b0 && err_sticky_o == 1'b0, "R10 after reset", {err_o, err_sticky_o}, 0);
  endtask

  task automatic t_fill;
    logic [AW-1:0] a[3] = '{16'h0000, 16'h0014, 16'hFFFC};
    logic [DW-1:0] d[3] = '{32'h0000_0000, 32'hDEAD_BEEF, 32'h0000_0001};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      fill_addr_i = a[i]; fill_data_i = d[i];
      #1 chk(fill_par_o == ref_par(a[i], d[i]), "R1 fill parity", fill_par_o, ref_par(a[i], d[i]));
    end
  endtask

  task automatic t_offset;
    logic p0;
    @(negedge clk);
    fill_addr_i = 16'h0120; fill_data_i = 32'h1234_5678;
    #1 p0 = fill_par_o;
    for (int o = 1; o < 4; o++) begin
      fill_addr_i = 16'h0120 | o[15:0];
      #1 chk(fill_par_o == p0, "R9 offset bits ignored", fill_par_o, p0);
    end
  endtask

  task automatic t_full_store;
    @(negedge clk);
    st_valid_i = 1'b1; st_addr_i = 16'h0040; st_be_i = 4'hF;
    st_wdata_i = 32'hA5A5_0F0F; st_old_data_i = 32'hFFFF_FFFF;
    #1;
    chk(st_data_o == 32'hA5A5_0F0F, "R2 full store data", st_data_o, 32'hA5A5_0F0F);
    chk(st_par_o == ref_par(16'h0040, 32'hA5A5_0F0F), "R2 full store parity",
        st_par_o, ref_par(16'h0040, 32'hA5A5_0F0F));
  endtask

  task automatic t_partial_store;
    logic [NB-1:0] be[3] = '{4'b0001, 4'b1010, 4'b0000};
    logic [DW-1:0] ex[3] = '{32'h1122_33CC, 32'hAA22_CC44, 32'h1122_3344};
    logic e;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      st_valid_i = 1'b1; st_addr_i = 16'h0088; st_be_i = be[i];
      st_wdata_i = 32'hAABB_CCCC; st_old_data_i = 32'h1122_3344;
      #1;
      chk(st_data_o == ex[i], "R3 merged word", st_data_o, ex[i]);
      chk(st_par_o == ref_par(16'h0088, ex[i]), "R3 merged parity", st_par_o, ref_par(16'h0088, ex[i]));
    end
    st_valid_i = 1'b0;
    do_load(16'h0088, ex[1], ref_par(16'h0088, ex[1]), 1'b1, e);
    chk(e == 1'b0, "R3 reload of merged word", e, 0);
  endtask

  task automatic t_load_good;
    logic e;
    do_load(16'h0200, 32'hCAFE_F00D, ref_par(16'h0200, 32'hCAFE_F00D), 1'b1, e);
    chk(e == 1'b0, "R4 clean load", e, 0);
    do_load(16'h7FFC, 32'h0000_0000, ref_par(16'h7FFC, 32'h0), 1'b1, e);
    chk(e == 1'b0, "R4 clean load zero", e, 0);
    chk(err_sticky_o == 1'b0, "R4 sticky clear", err_sticky_o, 0);
  endtask

  task automatic t_no_valid;
    logic e;
    do_load(16'h0300, 32'h0000_0001, ~ref_par(16'h0300, 32'h1), 1'b0, e);
    chk(e == 1'b0, "R7 mismatch without valid", e, 0);
    chk(err_sticky_o == 1'b0, "R7 sticky without valid", err_sticky_o, 0);
  endtask

  task automatic t_data_flip;
    logic e;
    logic [DW-1:0] d = 32'h0F0F_1234;
    logic p = ref_par(16'h0400, d);
    do_load(16'h0400, d ^ 32'h0001_0000, p, 1'b1, e);
    chk(e == 1'b1, "R5 flipped bit flagged", e, 1);
    chk(err_sticky_o == 1'b1, "R8 sticky set", err_sticky_o, 1);
    @(negedge clk); #1;
    chk(err_o == 1'b0, "R7 pulse one cycle", err_o, 0);
  endtask

  task automatic t_misroute;
    logic e;
    logic [DW-1:0] d = 32'h5555_0001;
    // stored at 0x0014 (word 5), requested 0x0010 (word 4): one bit apart
    do_load(16'h0010, d, ref_par(16'h0014, d), 1'b1, e);
    chk(e == 1'b1, "R6 odd distance misroute", e, 1);
    // stored at 0x001C (word 7), requested 0x0010 (word 4): two bits apart
    do_load(16'h0010, d, ref_par(16'h001C, d), 1'b1, e);
    chk(e == 1'b0, "R6 even distance aliases", e, 0);
  endtask

  task automatic t_back_to_back;
    logic [DW-1:0] d = 32'h8000_0000;
    logic p = ref_par(16'h0500, d);
    @(negedge clk);
    ld_valid_i = 1'b1; ld_addr_i = 16'h0500; ld_data_i = d; ld_par_i = ~p;
    @(negedge clk);
    ld_par_i = p;
    #1 chk(err_o == 1'b1, "R7 first of pair", err_o, 1);
    @(negedge clk);
    ld_valid_i = 1'b0;
    #1 chk(err_o == 1'b0, "R7 clean after error", err_o, 0);
    chk(err_sticky_o == 1'b1, "R8 sticky holds", err_sticky_o, 1);
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2;
    t_reset();
    t_fill();
    t_offset();
    t_full_store();
    t_partial_store();
    t_load_good();
    t_no_valid();
    t_data_flip();
    t_misroute();
    t_back_to_back();
    @(negedge clk);
    rst_ni = 1'b0;
    #1 chk(err_sticky_o == 1'b0, "R8 cleared by reset", err_sticky_o, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule